// File: doc/BRIEF.md
# Interrupt Pin Request and Acknowledge Tracker

This block sits between a bank of interrupt input pins and a delivery dispatcher inside an interrupt router. For every pin it turns the raw input into an effective level using a per-pin polarity bit. It keeps a pending-request bit and an in-service flag for each pin. It queues service requests and hands them to the dispatcher one at a time. Pin configuration (polarity, trigger type, mask, vector) arrives as flat vectors from an external register file. Destination selection and processor-side signalling are left to the dispatcher.

Edge-type pins drop their pending bit as soon as they are serviced. Level-type pins stay pending while the input is active. Once a delivery of a level-type pin reaches a target, that pin is held off by its in-service flag. An end-of-interrupt carries a vector and acts on every pin configured with that vector. It always produces a per-pin acknowledge notification. A level-type end-of-interrupt also releases the in-service flags and re-requests pins that are still pending and unmasked.

Top module: `irq_req_ack`

## Requirements
- R1: After reset, every pending bit and in-service flag is 0, `dlv_valid` is 0 and `ack_notify` is 0.
- R2: The effective level of pin i is `pin_raw[i] ^ cfg_polarity[i]`. A clock edge that samples an effective level of 0 leaves the pin's pending bit at 0 afterwards. Bit i of every vector port belongs to pin i.
- R3: An edge-type pin (`cfg_level[i]`=0) whose effective level rises sets its pending bit and requests service. The pending bit clears at the edge where the request is accepted (`dlv_valid && dlv_ready`).
- R4: A masked pin (`cfg_mask[i]`=1) is never offered on `dlv_valid`. On a rise, a masked edge-type pin leaves its pending bit at 0. A masked level-type pin sets its pending bit and keeps it while the input is active.
- R5: A level-type pin (`cfg_level[i]`=1) whose effective level rises sets its pending bit. It requests service only when its in-service flag is clear. A level-type pin keeps its pending bit through delivery.
- R6: An in-service flag is set only at an edge where `dlv_done` and `dlv_hit` are both 1 for an outstanding level-type delivery. A miss (`dlv_hit`=0) leaves it clear. `dlv_done` with no delivery outstanding has no effect.
- R7: Requested pins are offered in ascending pin order, one per delivery. After a handshake, `dlv_valid` stays low until `dlv_done` returns.
- R8: An end-of-interrupt (`eoi_valid`) applies to every pin whose `cfg_vector` field equals `eoi_vector`. `ack_notify` shows exactly those pins for the one cycle after that edge.
- R9: With `eoi_level`=1, each matching pin clears its in-service flag. A matching pin that is unmasked and still pending is requested again. With `eoi_level`=0, only the notification occurs.
- R10: While `dlv_valid` is 1, `dlv_vector` equals bits [i*VEC_W +: VEC_W] of `cfg_vector` and `dlv_level` equals `cfg_level[i]` for the offered pin i = `dlv_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NPINS | Raw pin levels |
| cfg_polarity | input | NPINS | 1 = pin is active low |
| cfg_level | input | NPINS | 1 = level-type, 0 = edge-type |
| cfg_mask | input | NPINS | 1 = pin masked |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector, pin i at [i*VEC_W +: VEC_W] |
| dlv_valid | output | 1 | Delivery request to dispatcher |
| dlv_ready | input | 1 | Dispatcher accepts request |
| dlv_pin | output | $clog2(NPINS) | Pin being offered |
| dlv_vector | output | VEC_W | Vector of offered pin |
| dlv_level | output | 1 | Trigger type of offered pin |
| dlv_done | input | 1 | Dispatcher result strobe |
| dlv_hit | input | 1 | Result: at least one target reached |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Acknowledged vector |
| eoi_level | input | 1 | 1 = level-type acknowledge |
| ack_notify | output | NPINS | Per-pin acknowledge notification pulse |
| pin_pending | output | NPINS | Pending-request bits |
| pin_in_service | output | NPINS | In-service flags |

## Verification
A stale in-service flag shows up as a missing delivery. The next rise of a level-type pin is not offered, and this is visible one cycle after that rise on `dlv_valid`. A lost or duplicated request shows up at the dispatcher interface within one delivery round trip: the order of `dlv_pin` changes, or there are too many or too few offers. A wrong vector compare shows up on `ack_notify` in the cycle right after the acknowledge. If it also affects re-requests, `dlv_valid` is wrong in that same cycle.

// File: rtl/irq_ra_pkg.sv
package irq_ra_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  // Effective pin level after polarity inversion.
  function automatic logic eff_level(input logic raw, input logic pol);
    return raw ^ pol;
  endfunction

endpackage

// File: rtl/irq_ra_level_track.sv
module irq_ra_level_track
  import irq_ra_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_raw,
  input  logic [NPINS-1:0] cfg_polarity,
  input  logic [NPINS-1:0] cfg_level,
  input  logic [NPINS-1:0] cfg_mask,
  input  logic [NPINS-1:0] in_service,
  input  logic [NPINS-1:0] take,
  output logic [NPINS-1:0] pending,
  output logic [NPINS-1:0] svc_trig
);

  logic [NPINS-1:0] eff;
  logic [NPINS-1:0] eff_q;
  logic [NPINS-1:0] rise;
  logic [NPINS-1:0] pending_n;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign eff[i]  = eff_level(pin_raw[i], cfg_polarity[i]);
    assign rise[i] = eff[i] & ~eff_q[i];

    // Edge pins: rise from a cleared pending bit always counts as a change.
    assign svc_trig[i] = rise[i] & ~cfg_mask[i] &
                         ((cfg_level[i] == TRIG_EDGE) ? ~pending[i] | ~in_service[i]
                                                      : ~in_service[i]);

    always_comb begin
      pending_n[i] = pending[i];
      if (!eff[i]) begin
        pending_n[i] = 1'b0;
      end else if (rise[i]) begin
        // A masked edge pin is serviced at once without delivery.
        pending_n[i] = ~((cfg_level[i] == TRIG_EDGE) & cfg_mask[i]);
      end else if (take[i] && (cfg_level[i] == TRIG_EDGE)) begin
        pending_n[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q   <= '0;
      pending <= '0;
    end else begin
      eff_q   <= eff;
      pending <= pending_n;
    end
  end

endmodule

// File: rtl/irq_ra_svc_queue.sv
module irq_ra_svc_queue #(
  parameter int NPINS = 8,
  parameter int VEC_W = 8,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   cfg_level,
  input  logic [NPINS-1:0]   cfg_mask,
  input  logic [NPINS*VEC_W-1:0] cfg_vector,
  input  logic [NPINS-1:0]   svc_trig,
  input  logic [NPINS-1:0]   retrig,
  output logic [NPINS-1:0]   take,
  output logic [NPINS-1:0]   res_set,
  output logic               dlv_valid,
  input  logic               dlv_ready,
  output logic [PIN_W-1:0]   dlv_pin,
  output logic [VEC_W-1:0]   dlv_vector,
  output logic               dlv_level,
  input  logic               dlv_done,
  input  logic               dlv_hit
);

  logic [NPINS-1:0] req;
  logic [NPINS-1:0] req_n;
  logic [NPINS-1:0] sel_oh;
  logic [PIN_W-1:0] sel;
  logic [PIN_W-1:0] infl;
  logic             busy;
  logic             busy_n;
  logic             any;
  logic             hs;
  logic             infl_en;

  // Lowest-numbered requester wins.
  always_comb begin
    sel = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (req[i]) sel = PIN_W'(i);
    end
  end

  assign any    = |req;
  assign sel_oh = req & (~req + NPINS'(1));

  assign dlv_valid  = ~busy & any & ~cfg_mask[sel];
  assign dlv_pin    = sel;
  assign dlv_vector = cfg_vector[sel*VEC_W +: VEC_W];
  assign dlv_level  = cfg_level[sel];

  assign hs      = dlv_valid & dlv_ready;
  assign infl_en = hs;
  assign take    = (~busy & any & (cfg_mask[sel] | dlv_ready)) ? sel_oh : '0;

  assign res_set = (busy & dlv_done & dlv_hit) ? ((NPINS'(1) << infl) & cfg_level) : '0;

  always_comb begin
    req_n  = (req & ~take) | svc_trig | retrig;
    busy_n = busy;
    if (hs) begin
      busy_n = 1'b1;
    end else if (busy && dlv_done) begin
      busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req  <= '0;
      busy <= 1'b0;
    end else begin
      req  <= req_n;
      busy <= busy_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      infl <= '0;
    end else if (infl_en) begin
      infl <= sel;
    end
  end

endmodule

// File: rtl/irq_ra_ack_track.sv
module irq_ra_ack_track #(
  parameter int NPINS = 8,
  parameter int VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       cfg_mask,
  input  logic [NPINS*VEC_W-1:0] cfg_vector,
  input  logic [NPINS-1:0]       pending,
  input  logic [NPINS-1:0]       res_set,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  input  logic                   eoi_level,
  output logic [NPINS-1:0]       in_service,
  output logic [NPINS-1:0]       retrig,
  output logic [NPINS-1:0]       ack_notify
);

  logic [NPINS-1:0] match;
  logic [NPINS-1:0] clr;
  logic [NPINS-1:0] isv_n;
  logic [NPINS-1:0] ack_n;

  for (genvar i = 0; i < NPINS; i++) begin : g_cmp
    assign match[i] = eoi_valid & (cfg_vector[i*VEC_W +: VEC_W] == eoi_vector);
  end

  assign clr    = match & {NPINS{eoi_level}};
  assign retrig = clr & ~cfg_mask & pending;

  always_comb begin
    // A fresh delivery result wins over a simultaneous release.
    isv_n = (in_service & ~clr) | res_set;
    ack_n = match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_service <= '0;
      ack_notify <= '0;
    end else begin
      in_service <= isv_n;
      ack_notify <= ack_n;
    end
  end

endmodule

// File: rtl/irq_req_ack.sv
module irq_req_ack #(
  parameter int NPINS = 8,
  parameter int VEC_W = 8,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_raw,
  input  logic [NPINS-1:0]       cfg_polarity,
  input  logic [NPINS-1:0]       cfg_level,
  input  logic [NPINS-1:0]       cfg_mask,
  input  logic [NPINS*VEC_W-1:0] cfg_vector,
  output logic                   dlv_valid,
  input  logic                   dlv_ready,
  output logic [PIN_W-1:0]       dlv_pin,
  output logic [VEC_W-1:0]       dlv_vector,
  output logic                   dlv_level,
  input  logic                   dlv_done,
  input  logic                   dlv_hit,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  input  logic                   eoi_level,
  output logic [NPINS-1:0]       ack_notify,
  output logic [NPINS-1:0]       pin_pending,
  output logic [NPINS-1:0]       pin_in_service
);

  logic [NPINS-1:0] take;
  logic [NPINS-1:0] svc_trig;
  logic [NPINS-1:0] retrig;
  logic [NPINS-1:0] res_set;

  irq_ra_level_track #(.NPINS(NPINS)) u_lvl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_raw      (pin_raw),
    .cfg_polarity (cfg_polarity),
    .cfg_level    (cfg_level),
    .cfg_mask     (cfg_mask),
    .in_service   (pin_in_service),
    .take         (take),
    .pending      (pin_pending),
    .svc_trig     (svc_trig)
  );

  irq_ra_svc_queue #(.NPINS(NPINS), .VEC_W(VEC_W)) u_q (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_level  (cfg_level),
    .cfg_mask   (cfg_mask),
    .cfg_vector (cfg_vector),
    .svc_trig   (svc_trig),
    .retrig     (retrig),
    .take       (take),
    .res_set    (res_set),
    .dlv_valid  (dlv_valid),
    .dlv_ready  (dlv_ready),
    .dlv_pin    (dlv_pin),
    .dlv_vector (dlv_vector),
    .dlv_level  (dlv_level),
    .dlv_done   (dlv_done),
    .dlv_hit    (dlv_hit)
  );

  irq_ra_ack_track #(.NPINS(NPINS), .VEC_W(VEC_W)) u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mask   (cfg_mask),
    .cfg_vector (cfg_vector),
    .pending    (pin_pending),
    .res_set    (res_set),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .eoi_level  (eoi_level),
    .in_service (pin_in_service),
    .retrig     (retrig),
    .ack_notify (ack_notify)
  );

endmodule

// File: rtl/irq_req_ack_chk.sv
module irq_req_ack_chk #(
  parameter int NPINS = 8,
  parameter int VEC_W = 8,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPINS-1:0]       pin_raw,
  input logic [NPINS-1:0]       cfg_polarity,
  input logic [NPINS-1:0]       cfg_mask,
  input logic                   dlv_valid,
  input logic                   dlv_ready,
  input logic [PIN_W-1:0]       dlv_pin,
  input logic                   dlv_done,
  input logic                   dlv_hit,
  input logic                   eoi_valid,
  input logic [NPINS-1:0]       ack_notify,
  input logic [NPINS-1:0]       pin_pending,
  input logic [NPINS-1:0]       pin_in_service
);

  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
    end else if (dlv_valid && dlv_ready) begin
      outstanding <= 1'b1;
    end else if (dlv_done) begin
      outstanding <= 1'b0;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !dlv_valid); // R7

  AST_ISV_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pin_in_service & ~$past(pin_in_service))) |-> $past(dlv_done && dlv_hit)); // R6

  AST_ACK_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_notify) |-> $past(eoi_valid)); // R8

  AST_OFFER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !cfg_mask[dlv_pin]); // R4

  AST_LOW_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(~(pin_raw ^ cfg_polarity)) & pin_pending) == '0); // R2

endmodule

bind irq_req_ack irq_req_ack_chk #(.NPINS(NPINS), .VEC_W(VEC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pin_raw        (pin_raw),
  .cfg_polarity   (cfg_polarity),
  .cfg_mask       (cfg_mask),
  .dlv_valid      (dlv_valid),
  .dlv_ready      (dlv_ready),
  .dlv_pin        (dlv_pin),
  .dlv_done       (dlv_done),
  .dlv_hit        (dlv_hit),
  .eoi_valid      (eoi_valid),
  .ack_notify     (ack_notify),
  .pin_pending    (pin_pending),
  .pin_in_service (pin_in_service)
);

// File: tb/sim_irq_req_ack.sv
module sim_irq_req_ack;

  localparam int NPINS = 8;
  localparam int VEC_W = 8;
  localparam int NROWS = 34;

  // Fixed configuration: level pins 2,4,5,6,7; masked 3,4; pin 7 active low.
  localparam logic [7:0] LVL  = 8'hF4;
  localparam logic [7:0] MSK  = 8'h18;
  localparam logic [7:0] POL  = 8'h80;

  // Row: raw, {rdy,done,hit,eoi,eoi_lvl}, eoi_vec, exp_valid, exp_pin,
  //      exp_pending, exp_in_service, exp_ack
  localparam logic [48:0] TBL [NROWS] = '{
    {8'h80, 5'b00000, 8'h00, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00},
    {8'h81, 5'b00000, 8'h00, 1'b1, 3'd0, 8'h01, 8'h00, 8'h00},
    {8'h81, 5'b10000, 8'h00, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00},
    {8'h80, 5'b01100, 8'h00, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00},
    {8'h86, 5'b00000, 8'h00, 1'b1, 3'd1, 8'h06, 8'h00, 8'h00},
    {8'h86, 5'b10000, 8'h00, 1'b0, 3'd0, 8'h04, 8'h00, 8'h00},
    {8'h86, 5'b01100, 8'h00, 1'b1, 3'd2, 8'h04, 8'h00, 8'h00},
    {8'h86, 5'b10000, 8'h00, 1'b0, 3'd0, 8'h04, 8'h00, 8'h00},
    {8'h86, 5'b01100, 8'h00, 1'b0, 3'd0, 8'h04, 8'h04, 8'h00},
    {8'h82, 5'b00000, 8'h00, 1'b0, 3'd0, 8'h00, 8'h04, 8'h00},
    {8'h86, 5'b00000, 8'h00, 1'b0, 3'd0, 8'h04, 8'h04, 8'h00},
    {8'h86, 5'b00011, 8'h22, 1'b1, 3'd2, 8'h04, 8'h00, 8'h04},
    {8'h86, 5'b10000, 8'h00, 1'b0, 3'd0, 8'h04, 8'h00, 8'h00},
    {8'h86, 5'b01000, 8'h00, 1'b0, 3'd0, 8'h04, 8'h00, 8'h00},
    {8'h80, 5'b00000, 8'h00, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00},
    {8'h88, 5'b00000, 8'h00, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00},
    {8'h90, 5'b00000, 8'h00, 1'b0, 3'd0, 8'h10, 8'h00, 8'h00},
    {8'h60, 5'b00000, 8'h00, 1'b1, 3'd5, 8'hE0, 8'h00, 8'h00},
    {8'h60, 5'b10000, 8'h00, 1'b0, 3'd0, 8'hE0, 8'h00, 8'h00},
    {8'h60, 5'b01100, 8'h00, 1'b1, 3'd6, 8'hE0, 8'h20, 8'h00},
    {8'h60, 5'b10000, 8'h00, 1'b0, 3'd0, 8'hE0, 8'h20, 8'h00},
    {8'h60, 5'b01100, 8'h00, 1'b1, 3'd7, 8'hE0, 8'h60, 8'h00},
    {8'h60, 5'b10000, 8'h00, 1'b0, 3'd0, 8'hE0, 8'h60, 8'h00},
    {8'h60, 5'b01100, 8'h00, 1'b0, 3'd0, 8'hE0, 8'hE0, 8'h00},
    {8'h60, 5'b00011, 8'h45, 1'b1, 3'd5, 8'hE0, 8'h80, 8'h70},
    {8'h80, 5'b00000, 8'h00, 1'b1, 3'd5, 8'h00, 8'h80, 8'h00},
    {8'h80, 5'b10000, 8'h00, 1'b0, 3'd0, 8'h00, 8'h80, 8'h00},
    {8'h80, 5'b01100, 8'h00, 1'b1, 3'd6, 8'h00, 8'hA0, 8'h00},
    {8'h80, 5'b10000, 8'h00, 1'b0, 3'd0, 8'h00, 8'hA0, 8'h00},
    {8'h80, 5'b01000, 8'h00, 1'b0, 3'd0, 8'h00, 8'hA0, 8'h00},
    {8'h80, 5'b00010, 8'h45, 1'b0, 3'd0, 8'h00, 8'hA0, 8'h70},
    {8'h80, 5'b00011, 8'h45, 1'b0, 3'd0, 8'h00, 8'h80, 8'h70},
    {8'h80, 5'b01100, 8'h00, 1'b0, 3'd0, 8'h00, 8'h80, 8'h00},
    {8'h80, 5'b00011, 8'h27, 1'b0, 3'd0, 8'h00, 8'h00, 8'h80}
  };

  logic                   clk;
  logic                   rst_n;
  logic [NPINS-1:0]       pin_raw;
  logic [NPINS*VEC_W-1:0] cfg_vector;
  logic                   dlv_valid;
  logic                   dlv_ready;
  logic [2:0]             dlv_pin;
  logic [VEC_W-1:0]       dlv_vector;
  logic                   dlv_level;
  logic                   dlv_done;
  logic                   dlv_hit;
  logic                   eoi_valid;
  logic [VEC_W-1:0]       eoi_vector;
  logic                   eoi_level;
  logic [NPINS-1:0]       ack_notify;
  logic [NPINS-1:0]       pin_pending;
  logic [NPINS-1:0]       pin_in_service;

  int n_chk;
  int n_fail;
  bit finished;

  irq_req_ack #(.NPINS(NPINS), .VEC_W(VEC_W)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .pin_raw        (pin_raw),
    .cfg_polarity   (POL),
    .cfg_level      (LVL),
    .cfg_mask       (MSK),
    .cfg_vector     (cfg_vector),
    .dlv_valid      (dlv_valid),
    .dlv_ready      (dlv_ready),
    .dlv_pin        (dlv_pin),
    .dlv_vector     (dlv_vector),
    .dlv_level      (dlv_level),
    .dlv_done       (dlv_done),
    .dlv_hit        (dlv_hit),
    .eoi_valid      (eoi_valid),
    .eoi_vector     (eoi_vector),
    .eoi_level      (eoi_level),
    .ack_notify     (ack_notify),
    .pin_pending    (pin_pending),
    .pin_in_service (pin_in_service)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vectors 0x20+i, except pins 4..6 share 0x45.
  function automatic logic [7:0] vec_of(input int p);
    return (p >= 4 && p <= 6) ? 8'h45 : 8'(8'h20 + p);
  endfunction

  function automatic string row_tag(input int r);
    case (r)
      0:                      return "R1";
      1, 2:                   return "R3";
      4, 5, 12, 18, 20, 22:   return "R7";
      6:                      return "R10";
      7, 10:                  return "R5";
      9, 14, 17, 25:          return "R2";
      11, 30, 33:             return "R9";
      15, 16:                 return "R4";
      24, 31:                 return "R8";
      default:                return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dlv_ready  = 1'b0;
    dlv_done   = 1'b0;
    dlv_hit    = 1'b0;
    eoi_valid  = 1'b0;
    eoi_vector = '0;
    eoi_level  = 1'b0;
  endtask

  task automatic check_quiet(input string tag);
    check(tag, {39'd0, dlv_valid, pin_pending, pin_in_service, ack_notify},
          {39'd0, 1'b0, 8'h00, 8'h00, 8'h00});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    n_chk = 0;
    n_fail = 0;
    finished = 0;
    for (int p = 0; p < NPINS; p++) cfg_vector[p*VEC_W +: VEC_W] = vec_of(p);
    pin_raw = 8'h80;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_quiet("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 after release");

    for (int r = 0; r < NROWS; r++) begin
      logic [48:0] row;
      logic        ev;
      logic [2:0]  ep;
      row = TBL[r];
      pin_raw    = row[48:41];
      dlv_ready  = row[40];
      dlv_done   = row[39];
      dlv_hit    = row[38];
      eoi_valid  = row[37];
      eoi_level  = row[36];
      eoi_vector = row[35:28];
      ev = row[27];
      ep = row[26:24];
      @(posedge clk);
      @(negedge clk);
      check(row_tag(r), {39'd0, dlv_valid, pin_pending, pin_in_service, ack_notify},
            {39'd0, ev, row[23:0]});
      if (ev) begin
        check(row_tag(r), {53'd0, dlv_pin, dlv_vector}, {53'd0, ep, vec_of(int'(ep))});
        check("R10 level", {63'd0, dlv_level}, {63'd0, LVL[ep]});
      end
    end
    idle_inputs();

    // R1: reset while requests are active.
    pin_raw = 8'h07;
    @(posedge clk);
    @(negedge clk);
    check("R3 pre-reset request", {63'd0, dlv_valid}, 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check_quiet("R1 mid-run reset");
    pin_raw = 8'h80;
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 release idle");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule